// File: doc/BRIEF.md
# Shared Subsystem Power Vote Arbiter

Several devices can share one power domain, here called a subsystem. Each device votes for the power state it wants its subsystem in. This block keeps those votes in a small per-subsystem table and decides which single state the subsystem may take. It follows one rule: the subsystem never goes deeper than its most awake voter asks for. States are 2-bit values: 0 is fully on, and 3 is the deepest off state.

A request gives a subsystem number, a requester tag and a signed requested state. After one cycle of table work, the block compares the resolved state with the subsystem's current field in the packed power-state image that the register engine exposes. If the two differ, it offers an update to the engine, naming the word, the bit offset and the new 2-bit field. When the engine reports that the update is done, the block reads the field back and answers with success or with a retry error. If they already match, it answers at once that nothing has to change. Requests for a subsystem number beyond the table are rejected.

Top module: `pwr_vote_arbiter`

## Requirements
- R1: After reset, req_ready is 1, upd_valid and rsp_valid are 0, every slot is empty and every slot state is 3.
- R2: A request whose req_id is NUM_SUBSYS (64) or above gets rsp_valid with rsp_code 2 (range) in the cycle after acceptance, never raises upd_valid and leaves the vote table unchanged.
- R3: A negative req_state is treated as 0, and a req_state above 3 is treated as 3.
- R4: The slot used is the lowest-numbered slot that is either empty or already holds req_tag. Tag value 0 is an ordinary tag. A repeated request from one tag replaces that tag's earlier vote.
- R5: The resolved state (rsp_state) is the minimum of all slot states of the subsystem after the new vote is stored, taken from a starting value of 3.
- R6: If no slot matches and none is empty, nothing is stored. The minimum then starts from the clamped requested state, and rsp_full_warn is 1 with the response.
- R7: An update names upd_word = id / 16 and upd_bit = 2·(id mod 16) in a 32-bit word, with upd_field equal to the resolved state.
- R8: If cur_status[2·id +: 2] already equals the resolved state, rsp_valid rises with rsp_code 1 (no change) in the cycle after acceptance, and no update is offered.
- R9: Otherwise upd_valid rises the cycle after that and stays high, with stable fields, until upd_ready. The block then waits for upd_cmpl. In that cycle it answers rsp_code 0 if the field read back equals the resolved state, and rsp_code 3 (retry) if not. rsp_valid and upd_valid are never high together.
- R10: req_ready is high only while no request is in progress, so at most one request is accepted per cycle and none while one is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Vote request present |
| req_ready | output | 1 | Block can take a request |
| req_id | input | ID_W (7) | Subsystem number |
| req_tag | input | TAG_W (8) | Requester tag |
| req_state | input | REQ_W (4) | Requested state, signed |
| cur_status | input | 2·NUM_SUBSYS (128) | Packed current power-state fields from the register engine |
| upd_valid | output | 1 | Update offered to the register engine |
| upd_ready | input | 1 | Engine takes the update |
| upd_word | output | WIDX_W (2) | Word index of the field |
| upd_bit | output | BOFF_W (5) | Bit offset of the field in its word |
| upd_field | output | 2 | New field value |
| upd_cmpl | input | 1 | Engine finished applying the update |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | 0 done, 1 no change, 2 range error, 3 retry |
| rsp_state | output | 2 | Resolved state |
| rsp_full_warn | output | 1 | Table was full for this request |

## Verification
The checks take for granted that the register engine drives upd_cmpl only after it has accepted an update, and that cur_status stays stable while a request waits between acceptance and its response. The checks also assume that req_state is a signed two's-complement value. The bench acts as the engine. It changes its status image only at the clock edge where it takes an update, and it raises upd_cmpl only in the verify phase. It sometimes writes a wrong field, so that the retry path is exercised.

// File: rtl/pva_pkg.sv
package pva_pkg;

   typedef logic [1:0] pstate_t;

   localparam pstate_t PST_AWAKE   = 2'd0;
   localparam pstate_t PST_DEEPEST = 2'd3;

   typedef enum logic [1:0] {
      RSP_DONE   = 2'd0,
      RSP_SAME   = 2'd1,
      RSP_RANGE  = 2'd2,
      RSP_RETRY  = 2'd3
   } rsp_code_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_EVAL,
      SQ_WRITE,
      SQ_VERIFY
   } seq_state_e;

endpackage

// File: rtl/pva_slot_table.sv
module pva_slot_table
   import pva_pkg::*;
#(
   parameter int NUM_SUBSYS = 64,
   parameter int SLOTS      = 4,
   parameter int TAG_W      = 8,
   parameter int SUB_W      = 6,
   parameter int SLOT_W     = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [SUB_W-1:0]               rd_sub,
   output logic [SLOTS-1:0]               rd_vld,
   output logic [SLOTS-1:0][TAG_W-1:0]    rd_tag,
   output logic [SLOTS-1:0][1:0]          rd_st,
   input  logic                           we,
   input  logic [SUB_W-1:0]               wr_sub,
   input  logic [SLOT_W-1:0]              wr_slot,
   input  logic [TAG_W-1:0]               wr_tag,
   input  pstate_t                        wr_st
);

   logic [SLOTS-1:0]            vld_all [NUM_SUBSYS];
   logic [SLOTS-1:0][TAG_W-1:0] tag_all [NUM_SUBSYS];
   logic [SLOTS-1:0][1:0]       st_all  [NUM_SUBSYS];

   for (genvar s = 0; s < NUM_SUBSYS; s++) begin : g_sub
      for (genvar k = 0; k < SLOTS; k++) begin : g_slot
         logic             vld_q;
         logic [TAG_W-1:0] tag_q;
         pstate_t          st_q;
         logic             hit_w;

         assign hit_w = we && (wr_sub == SUB_W'(s)) && (wr_slot == SLOT_W'(k));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               tag_q <= '0;
               st_q  <= PST_DEEPEST;
            end else if (hit_w) begin
               vld_q <= 1'b1;
               tag_q <= wr_tag;
               st_q  <= wr_st;
            end
         end

         assign vld_all[s][k] = vld_q;
         assign tag_all[s][k] = tag_q;
         assign st_all[s][k]  = st_q;
      end
   end

   assign rd_vld = vld_all[rd_sub];
   assign rd_tag = tag_all[rd_sub];
   assign rd_st  = st_all[rd_sub];

endmodule

// File: rtl/pva_resolver.sv
module pva_resolver
   import pva_pkg::*;
#(
   parameter int SLOTS  = 4,
   parameter int TAG_W  = 8,
   parameter int REQ_W  = 4,
   parameter int SLOT_W = 2
) (
   input  logic [SLOTS-1:0]            slot_vld,
   input  logic [SLOTS-1:0][TAG_W-1:0] slot_tag,
   input  logic [SLOTS-1:0][1:0]       slot_st,
   input  logic [TAG_W-1:0]            req_tag,
   input  logic signed [REQ_W-1:0]     req_state,
   output pstate_t                     req_clamped,
   output logic                        hit,
   output logic [SLOT_W-1:0]           hit_idx,
   output pstate_t                     resolved
);

   logic [SLOTS-1:0]      cand;
   logic [SLOTS-1:0][1:0] eff;

   always_comb begin
      if (req_state[REQ_W-1]) begin
         req_clamped = PST_AWAKE;
      end else if (req_state > $signed(REQ_W'(3))) begin
         req_clamped = PST_DEEPEST;
      end else begin
         req_clamped = pstate_t'(req_state[1:0]);
      end
   end

   for (genvar i = 0; i < SLOTS; i++) begin : g_cand
      assign cand[i] = !slot_vld[i] || (slot_tag[i] == req_tag);
   end

   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (cand[i]) begin
            hit     = 1'b1;
            hit_idx = SLOT_W'(i);
         end
      end
   end

   for (genvar i = 0; i < SLOTS; i++) begin : g_eff
      assign eff[i] = (hit && (hit_idx == SLOT_W'(i))) ? req_clamped : slot_st[i];
   end

   always_comb begin
      resolved = hit ? PST_DEEPEST : req_clamped;
      for (int i = 0; i < SLOTS; i++) begin
         if (eff[i] < resolved) begin
            resolved = eff[i];
         end
      end
   end

endmodule

// File: rtl/pva_sequencer.sv
module pva_sequencer
   import pva_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       range_err,
   input  logic       same,
   input  logic       upd_ready,
   input  logic       upd_cmpl,
   output logic       req_ready,
   output logic       accept,
   output logic       upd_valid,
   output logic       rsp_valid,
   output logic [1:0] rsp_code
);

   seq_state_e state_q, state_d;

   assign req_ready = (state_q == SQ_IDLE);
   assign accept    = req_ready && req_valid;
   assign upd_valid = (state_q == SQ_WRITE);

   always_comb begin
      state_d   = state_q;
      rsp_valid = 1'b0;
      rsp_code  = RSP_DONE;
      unique case (state_q)
         SQ_IDLE: begin
            if (req_valid) state_d = SQ_EVAL;
         end
         SQ_EVAL: begin
            if (range_err) begin
               rsp_valid = 1'b1;
               rsp_code  = RSP_RANGE;
               state_d   = SQ_IDLE;
            end else if (same) begin
               rsp_valid = 1'b1;
               rsp_code  = RSP_SAME;
               state_d   = SQ_IDLE;
            end else begin
               state_d   = SQ_WRITE;
            end
         end
         SQ_WRITE: begin
            if (upd_ready) state_d = SQ_VERIFY;
         end
         SQ_VERIFY: begin
            if (upd_cmpl) begin
               rsp_valid = 1'b1;
               rsp_code  = same ? RSP_DONE : RSP_RETRY;
               state_d   = SQ_IDLE;
            end
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SQ_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/pwr_vote_arbiter.sv
module pwr_vote_arbiter
   import pva_pkg::*;
#(
   parameter int NUM_SUBSYS = 64,
   parameter int SLOTS      = 4,
   parameter int TAG_W      = 8,
   parameter int ID_W       = 7,
   parameter int REQ_W      = 4,
   parameter int WORD_W     = 32,
   localparam int SUB_W     = $clog2(NUM_SUBSYS),
   localparam int FPW       = WORD_W / 2,
   localparam int FPW_LOG   = $clog2(FPW),
   localparam int NUM_WORDS = (NUM_SUBSYS * 2) / WORD_W,
   localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
   localparam int BOFF_W    = $clog2(WORD_W),
   localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [ID_W-1:0]           req_id,
   input  logic [TAG_W-1:0]          req_tag,
   input  logic signed [REQ_W-1:0]   req_state,
   input  logic [NUM_SUBSYS*2-1:0]   cur_status,
   output logic                      upd_valid,
   input  logic                      upd_ready,
   output logic [WIDX_W-1:0]         upd_word,
   output logic [BOFF_W-1:0]         upd_bit,
   output logic [1:0]                upd_field,
   input  logic                      upd_cmpl,
   output logic                      rsp_valid,
   output logic [1:0]                rsp_code,
   output logic [1:0]                rsp_state,
   output logic                      rsp_full_warn
);

   if (NUM_SUBSYS < 2 || (1 << SUB_W) != NUM_SUBSYS) begin : g_bad_sub
      $error("NUM_SUBSYS must be a power of two of at least 2");
   end
   if (ID_W < SUB_W) begin : g_bad_id
      $error("ID_W too narrow for NUM_SUBSYS");
   end
   if (SLOTS < 1) begin : g_bad_slots
      $error("SLOTS must be at least 1");
   end
   if (REQ_W < 3) begin : g_bad_req
      $error("REQ_W must hold a sign and the value 3");
   end
   if (WORD_W < 4 || (1 << BOFF_W) != WORD_W || (NUM_SUBSYS * 2) % WORD_W != 0) begin : g_bad_word
      $error("WORD_W must be a power of two dividing the status image");
   end

   logic [SUB_W-1:0]            req_sub;
   logic                        in_range;
   logic                        accept;
   logic [SLOTS-1:0]            t_vld;
   logic [SLOTS-1:0][TAG_W-1:0] t_tag;
   logic [SLOTS-1:0][1:0]       t_st;
   pstate_t                     clamped;
   logic                        hit;
   logic [SLOT_W-1:0]           hit_idx;
   pstate_t                     resolved;

   logic [SUB_W-1:0]            sub_q;
   pstate_t                     res_q;
   logic                        full_q;
   logic                        range_q;
   pstate_t                     cur_field;

   assign req_sub  = req_id[SUB_W-1:0];
   assign in_range = int'(req_id) < NUM_SUBSYS;

   pva_slot_table #(
      .NUM_SUBSYS (NUM_SUBSYS),
      .SLOTS      (SLOTS),
      .TAG_W      (TAG_W),
      .SUB_W      (SUB_W),
      .SLOT_W     (SLOT_W)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_sub  (req_sub),
      .rd_vld  (t_vld),
      .rd_tag  (t_tag),
      .rd_st   (t_st),
      .we      (accept && in_range && hit),
      .wr_sub  (req_sub),
      .wr_slot (hit_idx),
      .wr_tag  (req_tag),
      .wr_st   (clamped)
   );

   pva_resolver #(
      .SLOTS  (SLOTS),
      .TAG_W  (TAG_W),
      .REQ_W  (REQ_W),
      .SLOT_W (SLOT_W)
   ) u_resolve (
      .slot_vld    (t_vld),
      .slot_tag    (t_tag),
      .slot_st     (t_st),
      .req_tag     (req_tag),
      .req_state   (req_state),
      .req_clamped (clamped),
      .hit         (hit),
      .hit_idx     (hit_idx),
      .resolved    (resolved)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q   <= '0;
         res_q   <= PST_DEEPEST;
         full_q  <= 1'b0;
         range_q <= 1'b0;
      end else if (accept) begin
         sub_q   <= req_sub;
         res_q   <= resolved;
         full_q  <= in_range && !hit;
         range_q <= !in_range;
      end
   end

   assign cur_field = cur_status[{sub_q, 1'b0} +: 2];

   pva_sequencer u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .range_err (range_q),
      .same      (cur_field == res_q),
      .upd_ready (upd_ready),
      .upd_cmpl  (upd_cmpl),
      .req_ready (req_ready),
      .accept    (accept),
      .upd_valid (upd_valid),
      .rsp_valid (rsp_valid),
      .rsp_code  (rsp_code)
   );

   assign upd_word      = WIDX_W'(sub_q >> FPW_LOG);
   assign upd_bit       = BOFF_W'({sub_q[FPW_LOG-1:0], 1'b0});
   assign upd_field     = res_q;
   assign rsp_state     = res_q;
   assign rsp_full_warn = full_q;

endmodule

// File: rtl/pwr_vote_arbiter_chk.sv
module pwr_vote_arbiter_chk #(
   parameter int NUM_SUBSYS = 64,
   parameter int TAG_W      = 8,
   parameter int ID_W       = 7,
   parameter int REQ_W      = 4,
   parameter int WORD_W     = 32,
   parameter int WIDX_W     = 2,
   parameter int BOFF_W     = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic                    req_ready,
   input logic [ID_W-1:0]         req_id,
   input logic signed [REQ_W-1:0] req_state,
   input logic [NUM_SUBSYS*2-1:0] cur_status,
   input logic                    upd_valid,
   input logic                    upd_ready,
   input logic [WIDX_W-1:0]       upd_word,
   input logic [BOFF_W-1:0]       upd_bit,
   input logic [1:0]              upd_field,
   input logic                    rsp_valid,
   input logic [1:0]              rsp_code,
   input logic [1:0]              rsp_state
);

   // R10: no second acceptance while one request is outstanding
   p_single_flight_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R2: out-of-range subsystem answered with the range code next cycle
   p_range_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && int'(req_id) >= NUM_SUBSYS)
      |=> (rsp_valid && rsp_code == 2'd2 && !upd_valid));

   // R3: a request at or below zero forces the awake state
   p_clamp_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && int'(req_id) < NUM_SUBSYS && req_state <= 0)
      |=> (rsp_state == 2'd0));

   // R9: an offered update holds its fields until taken
   p_upd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_ready)
      |=> (upd_valid && $stable(upd_word) && $stable(upd_bit) && $stable(upd_field)));

   // R9: response and update offer never coincide
   p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !upd_valid);

   // R8: a no-change answer only when the current field matches
   p_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == 2'd1)
      |-> (cur_status[int'(upd_word) * WORD_W + int'(upd_bit) +: 2] == rsp_state));

endmodule

bind pwr_vote_arbiter pwr_vote_arbiter_chk #(
   .NUM_SUBSYS (NUM_SUBSYS),
   .TAG_W      (TAG_W),
   .ID_W       (ID_W),
   .REQ_W      (REQ_W),
   .WORD_W     (WORD_W),
   .WIDX_W     (WIDX_W),
   .BOFF_W     (BOFF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_id     (req_id),
   .req_state  (req_state),
   .cur_status (cur_status),
   .upd_valid  (upd_valid),
   .upd_ready  (upd_ready),
   .upd_word   (upd_word),
   .upd_bit    (upd_bit),
   .upd_field  (upd_field),
   .rsp_valid  (rsp_valid),
   .rsp_code   (rsp_code),
   .rsp_state  (rsp_state)
);

// File: tb/pwr_vote_arbiter_test.sv
`timescale 1ns/1ps
module pwr_vote_arbiter_test;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [6:0]        req_id = '0;
   logic [7:0]        req_tag = '0;
   logic signed [3:0] req_state = '0;
   logic [127:0]      stat = '1;
   logic              upd_valid;
   logic              upd_ready = 1'b0;
   logic [1:0]        upd_word;
   logic [4:0]        upd_bit;
   logic [1:0]        upd_field;
   logic              upd_cmpl = 1'b0;
   logic              rsp_valid;
   logic [1:0]        rsp_code;
   logic [1:0]        rsp_state;
   logic              rsp_full_warn;

   int checks = 0;
   int errors = 0;

   // behavioural vote model
   int  m_tag [64][4];
   bit  m_vld [64][4];
   int  m_st  [64][4];

   always #2.5 clk = ~clk;

   pwr_vote_arbiter uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_id(req_id), .req_tag(req_tag), .req_state(req_state),
      .cur_status(stat), .upd_valid(upd_valid), .upd_ready(upd_ready),
      .upd_word(upd_word), .upd_bit(upd_bit), .upd_field(upd_field),
      .upd_cmpl(upd_cmpl), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
      .rsp_state(rsp_state), .rsp_full_warn(rsp_full_warn));

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
      end
   endtask

   // every clock: response and update offer never together (R9)
   always @(negedge clk) begin
      if (rst_n) chk(!(rsp_valid && upd_valid), "R9 exclusive", int'(upd_valid), 0);
   end

   task automatic do_req(input int id, input int tag, input int st, input bit corrupt, input int dly);
      int  cs, res, slot, cur;
      bit  full;
      @(negedge clk);
      chk(req_ready == 1'b1, "R10 ready idle", int'(req_ready), 1);
      req_valid = 1'b1; req_id = 7'(id); req_tag = 8'(tag); req_state = 4'(st);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R10 busy", int'(req_ready), 0);
      if (id >= 64) begin
         chk(rsp_valid && rsp_code == 2'd2, "R2 range code", int'(rsp_code), 2);
         chk(upd_valid == 1'b0, "R2 no update", int'(upd_valid), 0);
         return;
      end
      cs = (st < 0) ? 0 : (st > 3) ? 3 : st;
      slot = -1;
      for (int j = 0; j < 4; j++) begin
         if (slot < 0 && (!m_vld[id][j] || m_tag[id][j] == tag)) slot = j;
      end
      full = (slot < 0);
      if (!full) begin
         m_vld[id][slot] = 1'b1; m_tag[id][slot] = tag; m_st[id][slot] = cs;
         res = 3;
      end else begin
         res = cs;
      end
      for (int j = 0; j < 4; j++) if (m_st[id][j] < res) res = m_st[id][j];
      cur = int'(stat[id*2 +: 2]);
      chk(int'(rsp_state) == res, "R5 resolved state (R3 R4)", int'(rsp_state), res);
      chk(rsp_full_warn == full, "R6 full warn", int'(rsp_full_warn), int'(full));
      if (cur == res) begin
         chk(rsp_valid && rsp_code == 2'd1, "R8 no change", int'(rsp_code), 1);
         return;
      end
      chk(rsp_valid == 1'b0, "R8 no early response", int'(rsp_valid), 0);
      @(negedge clk);
      chk(upd_valid == 1'b1, "R9 update offered", int'(upd_valid), 1);
      chk(int'(upd_word) == id / 16, "R7 word", int'(upd_word), id / 16);
      chk(int'(upd_bit) == (id % 16) * 2, "R7 bit", int'(upd_bit), (id % 16) * 2);
      chk(int'(upd_field) == res, "R7 field", int'(upd_field), res);
      for (int k = 0; k < dly; k++) begin
         @(negedge clk);
         chk(upd_valid == 1'b1, "R9 update held", int'(upd_valid), 1);
      end
      upd_ready = 1'b1;
      @(posedge clk);
      stat[id*2 +: 2] = corrupt ? 2'(res ^ 1) : 2'(res);
      @(negedge clk);
      upd_ready = 1'b0;
      chk(!upd_valid && !rsp_valid, "R9 waiting completion", int'(upd_valid), 0);
      upd_cmpl = 1'b1;
      #1;
      chk(rsp_valid && int'(rsp_code) == (corrupt ? 3 : 0), "R9 completion code",
          int'(rsp_code), corrupt ? 3 : 0);
      @(negedge clk);
      upd_cmpl = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] seed;
      for (int i = 0; i < 64; i++)
         for (int j = 0; j < 4; j++) begin
            m_vld[i][j] = 1'b0; m_tag[i][j] = 0; m_st[i][j] = 3;
         end
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && !upd_valid && !rsp_valid, "R1 reset outputs", int'(req_ready), 1);
      rst_n = 1'b1;
      do_req(5, 0, 3, 0, 0);   // R1 deep slots, R4 tag 0, R8
      do_req(5, 0, 0, 0, 2);   // R7 R9 update
      do_req(5, 1, 2, 0, 0);   // R5 min keeps 0
      do_req(5, 0, 3, 0, 1);   // R4 tag 0 replaced -> 2
      do_req(5, 2, 3, 0, 0);
      do_req(5, 3, 3, 0, 0);
      do_req(5, 4, 1, 0, 0);   // R6 full, starts from request
      do_req(5, 4, 3, 0, 0);   // R6 full, table unchanged -> 2
      do_req(63, 7, -5, 0, 0); // R3 clamp low, R7 last word
      do_req(40, 7, 7, 0, 0);  // R3 clamp high -> no change
      do_req(64, 1, 0, 0, 0);  // R2
      do_req(127, 1, 0, 0, 0); // R2
      do_req(17, 9, 1, 1, 0);  // R9 retry
      do_req(17, 9, 1, 0, 0);  // R9 recovers
      seed = 32'h1234_5677;
      for (int n = 0; n < 60; n++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         do_req(int'(seed[18:16]), int'(seed[23:20]) % 6, int'(seed[29:26]) % 9 - 3,
                seed[31:29] == 3'd0, int'(seed[9:8]) % 3);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule